// File: doc/BRIEF.md
# CAN Receive Mailbox Status Sequencer

This block keeps the receive-side status flags for a bank of CAN message slots. It sits between the frame receiver, the slot buffer writer and the register file that software reads. Software arms a slot by raising its receive-request bit. The protocol engine sends pulses when a frame begins, ends or aborts, and supplies the index of the slot that accepted the finished frame. The buffer writer sends a pulse when it has finished copying that frame into the slot.

When a frame completes into an armed slot, the slot's new-data bit is raised in the next cycle. The global success flag is raised in the same cycle. The slot's invalid-data bit is also raised to show that its contents are being rewritten. When the writer reports that the copy is done, the invalid-data bit drops, the slot's interrupt-status bit rises, and the global completed-slot number takes that slot's index. Software clears the sticky bits with one-cycle clear strobes. A hardware set in the same cycle always wins over a clear.

Top module: `can_rx_status`

## Requirements
- R1: After a synchronous active-low reset, all slot bits, `receiving`, `rx_succ` and `done_slot` are 0.
- R2: A `frm_start` pulse without `frm_end` or `frm_abort` sets `receiving` in the next cycle. The flag then holds until the frame ends or aborts.
- R3: `frm_end` or `frm_abort` clears `receiving` in the next cycle. Either one wins over a `frm_start` pulse in the same cycle.
- R4: A completion is accepted when all of these hold: `frm_end` is high, `frm_abort` is low, `rx_req[frm_slot]` is 1, and either no slot write is pending or `wr_done` is high in the same cycle. One cycle after an accepted completion, `new_data[frm_slot]`, `inv_data[frm_slot]` and `rx_succ` are all 1, and a slot write becomes pending for that slot.
- R5: A completion to a slot whose request bit is 0, or one that comes with `frm_abort`, changes no slot bit, `rx_succ` or `done_slot`.
- R6: A `wr_done` pulse while a write is pending does three things in the next cycle: it clears that slot's `inv_data`, sets its `irq_stat`, and loads its index into `done_slot`. A `wr_done` pulse with no write pending has no effect.
- R7: A completion that arrives while a write is pending, without `wr_done` in the same cycle, is dropped with no status change.
- R8: `sw_clr_new[i]` and `sw_clr_irq[i]` clear bit i of `new_data` and `irq_stat` in the next cycle. A hardware set of the same bit in the same cycle wins.
- R9: `rx_succ` stays at 1 until `sw_clr_succ` is pulsed. An accepted completion in the same cycle as the clear keeps it at 1.
- R10: At most one `inv_data` bit is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_req | input | 16 | Per-slot receive-request bits from software |
| frm_start | input | 1 | Frame reception began (pulse) |
| frm_end | input | 1 | Frame reception finished (pulse) |
| frm_abort | input | 1 | Frame abandoned on error (pulse) |
| frm_slot | input | 4 | Slot index accepting the finished frame, valid with `frm_end` |
| wr_done | input | 1 | Buffer writer finished storing the frame (pulse) |
| sw_clr_new | input | 16 | Software clear strobes for `new_data` |
| sw_clr_irq | input | 16 | Software clear strobes for `irq_stat` |
| sw_clr_succ | input | 1 | Software clear strobe for `rx_succ` |
| new_data | output | 16 | Per-slot new-data bits |
| inv_data | output | 16 | Per-slot invalid-data (being written) bits |
| irq_stat | output | 16 | Per-slot interrupt-status bits |
| receiving | output | 1 | A frame is being received |
| rx_succ | output | 1 | Sticky reception-success flag |
| done_slot | output | 4 | Index of the last slot whose write completed |

## Verification
Directed sequences send back-to-back frames into different armed slots and check each flag edge in its exact cycle. This shows whether invalid-data comes before interrupt-status and whether the slot number follows each frame. Unarmed targets, aborts, a completion while a write is still pending, and `wr_done` coinciding with a new completion are each applied on their own. These cases separate the acceptance conditions from one another. Same-cycle set/clear collisions show which side wins. A long seeded random run then mixes all of the pulse inputs, to catch interactions that the directed cases do not reach.

// File: rtl/can_rxs_pkg.sv
// Package: shared types for the receive status sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package can_rxs_pkg;
    // State of the single outstanding slot write.
    typedef enum logic {
        PEND_IDLE  = 1'b0,
        PEND_WRITE = 1'b1
    } pend_state_t;
endpackage

// File: rtl/can_rxs_frame_track.sv
// Module: tracks whether a frame is currently on the wire.
// Assumes: start/end/abort are single-cycle pulses from the protocol engine.
module can_rxs_frame_track (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_start,
    input  logic frm_end,
    input  logic frm_abort,
    output logic receiving
);
    logic stop;
    assign stop = frm_end | frm_abort;

    // Set on start, clear on end or abort (clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n)        receiving <= 1'b0;
        else if (stop)     receiving <= 1'b0;
        else if (frm_start) receiving <= 1'b1;
    end

    a_r2_recv_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && !stop) |=> receiving);
    a_r3_recv_clr: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !receiving);
endmodule

// File: rtl/can_rxs_flag_bank.sv
// Module: bank of sticky flags with per-bit set and clear, set wins.
// Assumes: set and clr are one-cycle masks.
module can_rxs_flag_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One flag: reset to 0, set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end

        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
        a_r8_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !q[i]);
    end
endmodule

// File: rtl/can_rxs_pending.sv
// Module: accepts frame completions and tracks the one slot write in flight.
// Assumes: the writer reports exactly one wr_done per accepted completion.
module can_rxs_pending
    import can_rxs_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] rx_req,
    input  logic                 frm_end,
    input  logic                 frm_abort,
    input  logic [SLOT_W-1:0]    frm_slot,
    input  logic                 wr_done,
    output logic                 accept,
    output logic                 wr_fire,
    output logic [SLOT_W-1:0]    pend_slot,
    output logic [SLOT_W-1:0]    done_slot
);
    pend_state_t state;

    // Completion qualified by request bit, no abort, and a free write slot.
    always_comb begin
        wr_fire = wr_done && (state == PEND_WRITE);
        accept  = frm_end && !frm_abort && rx_req[frm_slot]
                  && ((state == PEND_IDLE) || wr_done);
    end

    // Pending-write state and the slot it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PEND_IDLE;
            pend_slot <= '0;
        end else if (accept) begin
            state     <= PEND_WRITE;
            pend_slot <= frm_slot;
        end else if (wr_fire) begin
            state     <= PEND_IDLE;
        end
    end

    // Last completed slot number, loaded when its write finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)       done_slot <= '0;
        else if (wr_fire) done_slot <= pend_slot;
    end

    a_r6_done_slot: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (done_slot == $past(pend_slot)));
    a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PEND_WRITE && frm_end && !wr_done) |=> $stable(pend_slot));
    a_r6_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PEND_IDLE && !accept) |=> $stable(done_slot));
endmodule

// File: rtl/can_rx_status.sv
// Module: receive status sequencer for a bank of CAN message slots.
// Raises new/invalid/success on completion, swaps invalid for interrupt when
// the slot write finishes, and publishes the completed slot number.
// Assumes: software clears are one-cycle strobes; frm_slot valid with frm_end.
module can_rx_status #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] rx_req,
    input  logic                 frm_start,
    input  logic                 frm_end,
    input  logic                 frm_abort,
    input  logic [SLOT_W-1:0]    frm_slot,
    input  logic                 wr_done,
    input  logic [NUM_SLOTS-1:0] sw_clr_new,
    input  logic [NUM_SLOTS-1:0] sw_clr_irq,
    input  logic                 sw_clr_succ,
    output logic [NUM_SLOTS-1:0] new_data,
    output logic [NUM_SLOTS-1:0] inv_data,
    output logic [NUM_SLOTS-1:0] irq_stat,
    output logic                 receiving,
    output logic                 rx_succ,
    output logic [SLOT_W-1:0]    done_slot
);
    logic                 accept;
    logic                 wr_fire;
    logic [SLOT_W-1:0]    pend_slot;
    logic [NUM_SLOTS-1:0] acc_mask;
    logic [NUM_SLOTS-1:0] wr_mask;

    can_rxs_frame_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_start (frm_start),
        .frm_end   (frm_end),
        .frm_abort (frm_abort),
        .receiving (receiving)
    );

    can_rxs_pending #(.NUM_SLOTS(NUM_SLOTS)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_req    (rx_req),
        .frm_end   (frm_end),
        .frm_abort (frm_abort),
        .frm_slot  (frm_slot),
        .wr_done   (wr_done),
        .accept    (accept),
        .wr_fire   (wr_fire),
        .pend_slot (pend_slot),
        .done_slot (done_slot)
    );

    // Decode the accepted and the written slot into one-hot masks.
    always_comb begin
        acc_mask = '0;
        wr_mask  = '0;
        if (accept)  acc_mask[frm_slot]  = 1'b1;
        if (wr_fire) wr_mask[pend_slot]  = 1'b1;
    end

    can_rxs_flag_bank #(.WIDTH(NUM_SLOTS)) u_new (
        .clk(clk), .rst_n(rst_n), .set(acc_mask), .clr(sw_clr_new), .q(new_data));

    can_rxs_flag_bank #(.WIDTH(NUM_SLOTS)) u_inv (
        .clk(clk), .rst_n(rst_n), .set(acc_mask), .clr(wr_mask), .q(inv_data));

    can_rxs_flag_bank #(.WIDTH(NUM_SLOTS)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(wr_mask), .clr(sw_clr_irq), .q(irq_stat));

    can_rxs_flag_bank #(.WIDTH(1)) u_succ (
        .clk(clk), .rst_n(rst_n), .set(accept), .clr(sw_clr_succ), .q(rx_succ));

    a_r10_inv_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inv_data));
    a_r4_accept_flags: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rx_succ && inv_data[$past(frm_slot)] && new_data[$past(frm_slot)]));
    a_r5_reject_succ: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && !rx_req[frm_slot] && !sw_clr_succ) |=> $stable(rx_succ));
    a_r6_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> irq_stat[$past(pend_slot)]);
endmodule

// File: tb/can_rx_status_tb.sv
module can_rx_status_tb;
    localparam int N  = 16;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0] rx_req, sw_clr_new, sw_clr_irq;
    logic frm_start, frm_end, frm_abort, wr_done, sw_clr_succ;
    logic [SW-1:0] frm_slot;
    logic [N-1:0] new_data, inv_data, irq_stat;
    logic receiving, rx_succ;
    logic [SW-1:0] done_slot;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // expected state
    logic [N-1:0] m_new, m_inv, m_irq;
    logic m_recv, m_succ, m_pv;
    logic [SW-1:0] m_ps, m_done;

    always #10 clk = ~clk;

    can_rx_status u_dut (
        .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .frm_start(frm_start),
        .frm_end(frm_end), .frm_abort(frm_abort), .frm_slot(frm_slot),
        .wr_done(wr_done), .sw_clr_new(sw_clr_new), .sw_clr_irq(sw_clr_irq),
        .sw_clr_succ(sw_clr_succ), .new_data(new_data), .inv_data(inv_data),
        .irq_stat(irq_stat), .receiving(receiving), .rx_succ(rx_succ),
        .done_slot(done_slot));

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R4/R8 new_data", 32'(new_data), 32'(m_new));
        chk("R4/R6 inv_data", 32'(inv_data), 32'(m_inv));
        chk("R6/R8 irq_stat", 32'(irq_stat), 32'(m_irq));
        chk("R2/R3 receiving", 32'(receiving), 32'(m_recv));
        chk("R9 rx_succ", 32'(rx_succ), 32'(m_succ));
        chk("R6 done_slot", 32'(done_slot), 32'(m_done));
        chk("R10 inv onehot", 32'($countones(inv_data) <= 1), 32'd1);
    endtask

    task automatic clear_pulses();
        frm_start = 0; frm_end = 0; frm_abort = 0; wr_done = 0;
        sw_clr_new = '0; sw_clr_irq = '0; sw_clr_succ = 0;
    endtask

    // Expected next state from the requirements, given current inputs.
    task automatic cyc();
        logic acc, wf;
        logic [N-1:0] am, wm;
        acc = frm_end && !frm_abort && rx_req[frm_slot] && (!m_pv || wr_done);
        wf  = wr_done && m_pv;
        am  = acc ? (N'(1) << frm_slot) : '0;
        wm  = wf  ? (N'(1) << m_ps)     : '0;
        @(negedge clk);
        m_recv = (frm_end || frm_abort) ? 1'b0 : (frm_start ? 1'b1 : m_recv);
        m_new  = (m_new & ~sw_clr_new) | am;
        m_inv  = (m_inv & ~wm) | am;
        m_irq  = (m_irq & ~sw_clr_irq) | wm;
        m_succ = (m_succ & ~sw_clr_succ) | acc;
        if (wf) m_done = m_ps;
        if (acc) begin m_pv = 1'b1; m_ps = frm_slot; end
        else if (wf) m_pv = 1'b0;
        check_all();
        clear_pulses();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst_n = 0; rx_req = '0; frm_slot = '0; clear_pulses();
        m_new = '0; m_inv = '0; m_irq = '0; m_recv = 0; m_succ = 0;
        m_pv = 0; m_ps = '0; m_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 new_data", 32'(new_data), 0);
        chk("R1 inv_data", 32'(inv_data), 0);
        chk("R1 irq_stat", 32'(irq_stat), 0);
        chk("R1 flags", {30'd0, receiving, rx_succ}, 0);
        chk("R1 done_slot", 32'(done_slot), 0);

        rx_req = 16'h0228; // slots 3, 5, 9 armed
        // Frame into slot 3
        frm_start = 1; cyc();
        chk("R2 receiving set", 32'(receiving), 1);
        cyc(); cyc();
        chk("R2 receiving held", 32'(receiving), 1);
        frm_end = 1; frm_slot = 4'd3; cyc();
        chk("R4 new[3]", 32'(new_data[3]), 1);
        chk("R4 inv[3]", 32'(inv_data[3]), 1);
        chk("R4 succ", 32'(rx_succ), 1);
        chk("R4 irq[3] not yet", 32'(irq_stat[3]), 0);
        chk("R3 receiving clr", 32'(receiving), 0);
        wr_done = 1; cyc();
        chk("R6 inv[3] clr", 32'(inv_data[3]), 0);
        chk("R6 irq[3] set", 32'(irq_stat[3]), 1);
        chk("R6 done_slot 3", 32'(done_slot), 3);
        // Back-to-back frame into slot 5
        frm_start = 1; cyc();
        frm_end = 1; frm_slot = 4'd5; cyc();
        chk("R4 inv[5]", 32'(inv_data[5]), 1);
        chk("R6 done_slot still 3", 32'(done_slot), 3);
        wr_done = 1; cyc();
        chk("R6 irq[5]", 32'(irq_stat[5]), 1);
        chk("R6 done_slot 5", 32'(done_slot), 5);
        // R5: unarmed slot 7 and aborted slot 9
        frm_start = 1; cyc();
        frm_end = 1; frm_slot = 4'd7; cyc();
        chk("R5 unarmed new[7]", 32'(new_data[7]), 0);
        chk("R5 unarmed inv", 32'(inv_data), 0);
        frm_start = 1; cyc();
        frm_end = 1; frm_abort = 1; frm_slot = 4'd9; cyc();
        chk("R5 abort new[9]", 32'(new_data[9]), 0);
        chk("R3 abort receiving", 32'(receiving), 0);
        // R6: wr_done with nothing pending
        wr_done = 1; cyc();
        chk("R6 idle wr_done irq", 32'(irq_stat), 32'h0028);
        chk("R6 idle wr_done slot", 32'(done_slot), 5);
        // R7: second completion while busy is dropped
        sw_clr_new[5] = 1; cyc();
        frm_end = 1; frm_slot = 4'd9; cyc();
        frm_end = 1; frm_slot = 4'd5; cyc();
        chk("R7 dropped new[5]", 32'(new_data[5]), 0);
        chk("R7 inv only 9", 32'(inv_data), 32'h0200);
        // R7: completion with wr_done same cycle is taken; R8 collision
        frm_end = 1; frm_slot = 4'd5; wr_done = 1; sw_clr_new[5] = 1; cyc();
        chk("R7 inv moves to 5", 32'(inv_data), 32'h0020);
        chk("R6 irq[9]", 32'(irq_stat[9]), 1);
        chk("R6 done_slot 9", 32'(done_slot), 9);
        chk("R8 set beats clear new[5]", 32'(new_data[5]), 1);
        sw_clr_irq[5] = 1; wr_done = 1; cyc();
        chk("R8 set beats clear irq[5]", 32'(irq_stat[5]), 1);
        sw_clr_irq[5] = 1; sw_clr_new[3] = 1; cyc();
        chk("R8 clear irq[5]", 32'(irq_stat[5]), 0);
        chk("R8 clear new[3]", 32'(new_data[3]), 0);
        // R9: success sticky, clear, and set-wins
        cyc();
        chk("R9 succ held", 32'(rx_succ), 1);
        sw_clr_succ = 1; cyc();
        chk("R9 succ cleared", 32'(rx_succ), 0);
        frm_end = 1; frm_slot = 4'd3; sw_clr_succ = 1; cyc();
        chk("R9 set beats clear", 32'(rx_succ), 1);
        wr_done = 1; cyc();
        // R3: start and end together
        frm_start = 1; frm_end = 1; frm_slot = 4'd7; cyc();
        chk("R3 end wins start", 32'(receiving), 0);

        // Seeded random mix
        for (int k = 0; k < 4000; k++) begin
            if (($urandom % 16) == 0) rx_req = N'($urandom);
            frm_start   = ($urandom % 5) == 0;
            frm_end     = ($urandom % 4) == 0;
            frm_abort   = ($urandom % 12) == 0;
            frm_slot    = SW'($urandom);
            wr_done     = ($urandom % 3) == 0;
            sw_clr_new  = (($urandom % 4) == 0) ? N'($urandom) : '0;
            sw_clr_irq  = (($urandom % 4) == 0) ? N'($urandom) : '0;
            sw_clr_succ = ($urandom % 8) == 0;
            cyc();
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule